// File: doc/BRIEF.md
# SPI Transmit/Receive Word Buffers

This block holds the two word queues of an SPI controller. It sits between the register-bus side and the serial engine. The bus side pushes words into the transmit queue and pops words from the receive queue. The serial engine pops from the transmit queue and pushes into the receive queue. Both queues have the same configurable depth, which may be any value from 2 to 31 entries and need not be a power of two. Each queue reports its fill level every cycle.

Four limit registers hold values for the two queues: one interrupt threshold and one DMA watermark per queue. A limit register keeps a written value only when that value is below the queue depth. Software can therefore find the depth by writing rising values and reading each one back; the first value that does not read back equals the depth. Threshold comparisons produce two interrupt-level outputs. The watermark comparisons, gated by a two-bit DMA enable, produce one transmit request and one receive request. A packed status word reports the engine busy flag and the full and empty flags of both queues. The two kinds of software misuse are refused and signalled as one-cycle error pulses: a push to a full transmit queue and a pop from an empty receive queue.

Top module: `spiq_buffers`

## Requirements
- R1: After reset, both levels read 0 and `status` reads 0x0C while `engine_busy` is low. All four limit registers and `dma_en` read 0, both DMA requests are low, `tx_thr_irq` is high and `rx_thr_irq` is low.
- R2: Each queue delivers words in the order they were pushed, and its data output shows the oldest entry while the queue is not empty. An accepted push raises the level by one in the next cycle and an accepted pop lowers it by one. An accepted push and an accepted pop in the same cycle leave the level unchanged.
- R3: `status` bit 0 follows `engine_busy` in the same cycle. Bit 1 is transmit full, bit 2 transmit empty, bit 3 receive empty and bit 4 receive full.
- R4: `cfg_we` selects a limit register: bit 0 the transmit threshold, bit 1 the receive threshold, bit 2 the transmit watermark, bit 3 the receive watermark. A selected register takes `cfg_wdata` at the clock edge only if the value is below DEPTH. Otherwise it keeps its previous value.
- R5: `tx_thr_irq` is high while the transmit level is at or below the transmit threshold. `rx_thr_irq` is high while the receive level is above the receive threshold.
- R6: `dma_en_we` loads `dma_en`. Bit 0 enables the receive request and bit 1 enables the transmit request. A request whose enable bit is clear stays low.
- R7: When enabled, `tx_dma_req` is high while the transmit level is at or below the transmit watermark. Watermark 0 means the request is high only when the queue is empty. When enabled, `rx_dma_req` is high while the receive level is above the receive watermark. Watermark 0 means the request is high whenever at least one entry is present.
- R8: A bus push while the transmit queue is full is dropped and raises `tx_overflow` in the same cycle. This holds even when the engine pops in that cycle. The stored words are not disturbed.
- R9: A bus pop while the receive queue is empty is dropped and raises `rx_underflow` in the same cycle. The level stays 0.
- R10: An engine pop from an empty transmit queue and an engine push into a full receive queue are dropped without any error pulse. The level of the queue concerned does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_tx_push | input | 1 | Bus side writes a word into the transmit queue |
| bus_tx_data | input | DW | Word to enqueue for transmission |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | DW | Oldest transmit word |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_data | input | DW | Received word |
| bus_rx_pop | input | 1 | Bus side reads the oldest received word |
| bus_rx_data | output | DW | Oldest received word |
| cfg_we | input | 4 | Limit register write strobes (see R4) |
| cfg_wdata | input | CFG_W | Value for the selected limit register |
| dma_en_we | input | 1 | Load strobe for the DMA enables |
| dma_en_wdata | input | 2 | New DMA enable value |
| tx_thr | output | LVL_W | Transmit interrupt threshold |
| rx_thr | output | LVL_W | Receive interrupt threshold |
| tx_wm | output | LVL_W | Transmit DMA watermark |
| rx_wm | output | LVL_W | Receive DMA watermark |
| dma_en | output | 2 | DMA enables, bit 0 receive, bit 1 transmit |
| tx_level | output | LVL_W | Entries in the transmit queue |
| rx_level | output | LVL_W | Entries in the receive queue |
| engine_busy | input | 1 | Serial engine busy indication |
| status | output | 5 | Packed status word (see R3) |
| tx_thr_irq | output | 1 | Transmit level at or below threshold |
| rx_thr_irq | output | 1 | Receive level above threshold |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_overflow | output | 1 | Refused push to a full transmit queue |
| rx_underflow | output | 1 | Refused pop from an empty receive queue |

## Verification
A bus push and an engine pop on the transmit queue can fall in the same cycle, and the bench provokes this twice. The first time the queue is partly filled, and the level must stay put while the oldest word leaves. The second time the queue is full: the push must be refused with an overflow pulse even though the pop frees a slot in that cycle, and the level must fall by one. The pulse is judged before the clock edge and the level after it. Draining the queue afterwards shows that the refused word never entered and that order was kept.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

  localparam int N_LIM      = 4;
  localparam int IDX_TX_THR = 0;
  localparam int IDX_RX_THR = 1;
  localparam int IDX_TX_WM  = 2;
  localparam int IDX_RX_WM  = 3;

  // status word, most significant field first
  typedef struct packed {
    logic rx_full;
    logic rx_empty;
    logic tx_empty;
    logic tx_full;
    logic busy;
  } status_t;

  function automatic int next_level(input int lvl, input logic up, input logic dn);
    if (up && !dn) return lvl + 1;
    if (dn && !up) return lvl - 1;
    return lvl;
  endfunction

  function automatic int wrap_inc(input int ptr, input int depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  function automatic logic limit_ok(input int value, input int depth);
    return value < depth;
  endfunction

  // "room" style compare: fire while the level has fallen to the limit
  function automatic logic at_or_below(input int lvl, input int lim, input logic en);
    return en && (lvl <= lim);
  endfunction

  // "data" style compare: fire while the level exceeds the limit
  function automatic logic above(input int lvl, input int lim, input logic en);
    return en && (lvl > lim);
  endfunction

endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo
  import spiq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    pop_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push_rej,
  output logic             pop_rej
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             push_ok;
  logic             pop_ok;

  assign full     = (level == FULL_LVL);
  assign empty    = (level == '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign push_rej = push && !push_ok;
  assign pop_rej  = pop && !pop_ok;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(wrap_inc(int'(rd_ptr), DEPTH));
      level <= LVL_W'(next_level(int'(level), push_ok, pop_ok));
    end
  end

endmodule

// File: rtl/spiq_limit_reg.sv
module spiq_limit_reg
  import spiq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CFG_W = 5,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [LVL_W-1:0] q
);

  logic take;

  assign take = we && limit_ok(int'(wdata), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (take) q <= LVL_W'(wdata);
  end

endmodule

// File: rtl/spiq_req_gen.sv
module spiq_req_gen
  import spiq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic [LVL_W-1:0] tx_wm,
  input  logic [LVL_W-1:0] rx_wm,
  input  logic [1:0]       dma_en,
  output logic             tx_thr_hit,
  output logic             rx_thr_hit,
  output logic             tx_req,
  output logic             rx_req
);

  assign tx_thr_hit = at_or_below(int'(tx_level), int'(tx_thr), 1'b1);
  assign rx_thr_hit = above(int'(rx_level), int'(rx_thr), 1'b1);
  assign tx_req     = at_or_below(int'(tx_level), int'(tx_wm), dma_en[1]);
  assign rx_req     = above(int'(rx_level), int'(rx_wm), dma_en[0]);

endmodule

// File: rtl/spiq_buffers.sv
module spiq_buffers
  import spiq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int CFG_W = 5,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tx_push,
  input  logic [DW-1:0]    bus_tx_data,
  input  logic             eng_tx_pop,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [DW-1:0]    eng_rx_data,
  input  logic             bus_rx_pop,
  output logic [DW-1:0]    bus_rx_data,
  input  logic [3:0]       cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             dma_en_we,
  input  logic [1:0]       dma_en_wdata,
  output logic [LVL_W-1:0] tx_thr,
  output logic [LVL_W-1:0] rx_thr,
  output logic [LVL_W-1:0] tx_wm,
  output logic [LVL_W-1:0] rx_wm,
  output logic [1:0]       dma_en,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level,
  input  logic             engine_busy,
  output logic [4:0]       status,
  output logic             tx_thr_irq,
  output logic             rx_thr_irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  output logic             tx_overflow,
  output logic             rx_underflow
);

  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_push_rej, tx_pop_rej;
  logic             rx_push_rej, rx_pop_rej;
  logic [LVL_W-1:0] lim_q [N_LIM];
  status_t          st;

  spiq_fifo #(.DEPTH(DEPTH), .DW(DW), .LVL_W(LVL_W)) u_txq (
    .clk, .rst_n,
    .push(bus_tx_push), .push_data(bus_tx_data),
    .pop(eng_tx_pop),   .pop_data(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_rej(tx_push_rej), .pop_rej(tx_pop_rej)
  );

  spiq_fifo #(.DEPTH(DEPTH), .DW(DW), .LVL_W(LVL_W)) u_rxq (
    .clk, .rst_n,
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(bus_rx_pop),   .pop_data(bus_rx_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_rej(rx_push_rej), .pop_rej(rx_pop_rej)
  );

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    spiq_limit_reg #(.DEPTH(DEPTH), .CFG_W(CFG_W), .LVL_W(LVL_W)) u_lim (
      .clk, .rst_n, .we(cfg_we[g]), .wdata(cfg_wdata), .q(lim_q[g])
    );
  end

  assign tx_thr = lim_q[IDX_TX_THR];
  assign rx_thr = lim_q[IDX_RX_THR];
  assign tx_wm  = lim_q[IDX_TX_WM];
  assign rx_wm  = lim_q[IDX_RX_WM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dma_en <= 2'b00;
    else if (dma_en_we) dma_en <= dma_en_wdata;
  end

  spiq_req_gen #(.LVL_W(LVL_W)) u_req (
    .tx_level, .rx_level, .tx_thr, .rx_thr, .tx_wm, .rx_wm, .dma_en,
    .tx_thr_hit(tx_thr_irq), .rx_thr_hit(rx_thr_irq),
    .tx_req(tx_dma_req), .rx_req(rx_dma_req)
  );

  always_comb begin
    st.busy     = engine_busy;
    st.tx_full  = tx_full;
    st.tx_empty = tx_empty;
    st.rx_empty = rx_empty;
    st.rx_full  = rx_full;
  end

  assign status       = st;
  assign tx_overflow  = tx_push_rej;
  assign rx_underflow = rx_pop_rej;

endmodule

module spiq_buffers_chk #(
  parameter int DEPTH = 16,
  parameter int CFG_W = 5,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_tx_push,
  input logic             eng_tx_pop,
  input logic             eng_rx_push,
  input logic             bus_rx_pop,
  input logic [3:0]       cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [1:0]       dma_en,
  input logic [LVL_W-1:0] tx_thr,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] rx_wm,
  input logic [4:0]       status,
  input logic             tx_dma_req,
  input logic             rx_dma_req,
  input logic             tx_overflow,
  input logic             rx_underflow,
  input logic             tx_pop_rej,
  input logic             rx_push_rej
);

  localparam logic [CFG_W-1:0] DEPTH_C = CFG_W'(DEPTH);
  localparam logic [LVL_W-1:0] FULL_C  = LVL_W'(DEPTH);

  // R2
  tx_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tx_push && !status[1] && !eng_tx_pop |=> tx_level == $past(tx_level) + LVL_W'(1));

  // R3
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]) && !(status[3] && status[4]));

  // R4
  lim_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we[0] && cfg_wdata >= DEPTH_C |=> $stable(tx_thr));

  // R4
  lim_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we[0] && cfg_wdata < DEPTH_C |=> tx_thr == $past(cfg_wdata[LVL_W-1:0]));

  // R6
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en[1] |-> !tx_dma_req);

  // R6
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en[0] |-> !rx_dma_req);

  // R7
  rx_wm0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en[0] && rx_wm == '0 |-> rx_dma_req == (rx_level != '0));

  // R8
  tx_ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |-> status[1]);

  // R8
  tx_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow && !eng_tx_pop |=> tx_level == $past(tx_level));

  // R9
  rx_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rx_pop && rx_level == '0 |-> rx_underflow);

  // R9
  rx_udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underflow && !eng_rx_push |=> rx_level == '0);

  // R10
  tx_quiet_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_rej |-> tx_level == '0 && !tx_overflow);

  // R10
  rx_quiet_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_rej |-> rx_level == FULL_C && !rx_underflow);

endmodule

bind spiq_buffers spiq_buffers_chk #(.DEPTH(DEPTH), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/tb_spiq_buffers.sv
`timescale 1ns/1ps
module tb_spiq_buffers;

  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int CFG_W = 5;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_tx_push = 0, eng_tx_pop = 0, eng_rx_push = 0, bus_rx_pop = 0;
  logic [DW-1:0]    bus_tx_data = '0, eng_rx_data = '0;
  logic [DW-1:0]    eng_tx_data, bus_rx_data;
  logic [3:0]       cfg_we = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             dma_en_we = 0;
  logic [1:0]       dma_en_wdata = '0;
  logic [LVL_W-1:0] tx_thr, rx_thr, tx_wm, rx_wm, tx_level, rx_level;
  logic [1:0]       dma_en;
  logic             engine_busy = 0;
  logic [4:0]       status;
  logic             tx_thr_irq, rx_thr_irq, tx_dma_req, rx_dma_req, tx_overflow, rx_underflow;

  int nchk = 0;
  int nfail = 0;
  int txq[$];
  int rxq[$];

  always #2.5 clk = ~clk;

  spiq_buffers #(.DEPTH(DEPTH), .DW(DW), .CFG_W(CFG_W)) dut (
    .clk, .rst_n, .bus_tx_push, .bus_tx_data, .eng_tx_pop, .eng_tx_data,
    .eng_rx_push, .eng_rx_data, .bus_rx_pop, .bus_rx_data,
    .cfg_we, .cfg_wdata, .dma_en_we, .dma_en_wdata,
    .tx_thr, .rx_thr, .tx_wm, .rx_wm, .dma_en, .tx_level, .rx_level,
    .engine_busy, .status, .tx_thr_irq, .rx_thr_irq,
    .tx_dma_req, .rx_dma_req, .tx_overflow, .rx_underflow
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_status(input logic busy);
    return {rxq.size() == DEPTH, rxq.size() == 0, txq.size() == 0, txq.size() == DEPTH, busy};
  endfunction

  task automatic txop(input string tag, input bit push, input int data, input bit pop);
    bit ovf = push && (txq.size() == DEPTH);
    bit pop_ok = pop && (txq.size() > 0);
    bus_tx_push = push; bus_tx_data = DW'(data); eng_tx_pop = pop;
    #1;
    chk({tag, " tx_overflow"}, tx_overflow, ovf);
    if (pop_ok) chk({tag, " tx data"}, eng_tx_data, txq[0]);
    tick();
    bus_tx_push = 0; eng_tx_pop = 0;
    if (pop_ok) void'(txq.pop_front());
    if (push && !ovf) txq.push_back(data);
    chk({tag, " tx level"}, tx_level, txq.size());
  endtask

  task automatic rxop(input string tag, input bit push, input int data, input bit pop);
    bit udf = pop && (rxq.size() == 0);
    bit push_ok = push && (rxq.size() < DEPTH);
    eng_rx_push = push; eng_rx_data = DW'(data); bus_rx_pop = pop;
    #1;
    chk({tag, " rx_underflow"}, rx_underflow, udf);
    if (pop && !udf) chk({tag, " rx data"}, bus_rx_data, rxq[0]);
    tick();
    eng_rx_push = 0; bus_rx_pop = 0;
    if (pop && !udf) void'(rxq.pop_front());
    if (push_ok) rxq.push_back(data);
    chk({tag, " rx level"}, rx_level, rxq.size());
  endtask

  task automatic cfgw(input logic [3:0] sel, input int val);
    cfg_we = sel; cfg_wdata = CFG_W'(val);
    tick();
    cfg_we = '0;
  endtask

  task automatic dmaw(input logic [1:0] v);
    dma_en_we = 1; dma_en_wdata = v;
    tick();
    dma_en_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 status", status, 5'h0C);
    chk("R1 limits", {tx_thr, rx_thr, tx_wm, rx_wm}, 0);
    chk("R1 dma_en", dma_en, 0);
    chk("R1 requests", {tx_dma_req, rx_dma_req}, 0);
    chk("R1 tx_thr_irq", tx_thr_irq, 1);
    chk("R1 rx_thr_irq", rx_thr_irq, 0);
  endtask

  task automatic t_tx_order();
    for (int i = 0; i < DEPTH; i++) txop("R2", 1, 'hA500 + i, 0);
    chk("R3 status tx full", status, exp_status(0));
    txop("R8", 1, 'hBEEF, 0);
    for (int i = 0; i < DEPTH; i++) txop("R2", 0, 0, 1);
    chk("R3 status tx empty", status, exp_status(0));
  endtask

  task automatic t_simul();
    for (int i = 1; i <= 3; i++) txop("R2", 1, i, 0);
    txop("R2 push+pop", 1, 4, 1);
    while (txq.size() < DEPTH) txop("R2", 1, 'h100 + txq.size(), 0);
    txop("R8 full push+pop", 1, 'h77, 1);
    while (txq.size() > 0) txop("R8 drain", 0, 0, 1);
  endtask

  task automatic t_tx_quiet();
    txop("R10 empty tx pop", 0, 0, 1);
  endtask

  task automatic t_rx_path();
    rxop("R9", 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) rxop("R2", 1, 'h5A00 + i, 0);
    chk("R3 status rx full", status, exp_status(0));
    rxop("R10 full rx push", 1, 'hDEAD, 0);
    for (int i = 0; i < DEPTH; i++) rxop("R2", 0, 0, 1);
    rxop("R9 again", 0, 0, 1);
    chk("R3 status rx empty", status, exp_status(0));
  endtask

  task automatic t_limits();
    int found = -1;
    cfgw(4'b0001, 7);  chk("R4 tx_thr take", tx_thr, 7);
    cfgw(4'b0001, 16); chk("R4 tx_thr reject depth", tx_thr, 7);
    cfgw(4'b0001, 31); chk("R4 tx_thr reject 31", tx_thr, 7);
    cfgw(4'b0001, 15); chk("R4 tx_thr take max", tx_thr, 15);
    cfgw(4'b0010, 9);  chk("R4 rx_thr take", rx_thr, 9);
    cfgw(4'b0010, 20); chk("R4 rx_thr reject", rx_thr, 9);
    cfgw(4'b0100, 3);  chk("R4 tx_wm take", tx_wm, 3);
    cfgw(4'b1000, 5);  chk("R4 rx_wm take", rx_wm, 5);
    cfgw(4'b1000, 17); chk("R4 rx_wm reject", rx_wm, 5);
    chk("R4 others untouched", {tx_thr, rx_thr, tx_wm}, {5'd15, 5'd9, 5'd3});
    for (int v = 2; v < 32; v++) begin
      cfgw(4'b0001, v);
      if (int'(tx_thr) != v) begin found = v; break; end
    end
    chk("R4 depth discovery", found, DEPTH);
    cfgw(4'b1111, 0);
  endtask

  task automatic t_irq();
    cfgw(4'b0011, DEPTH / 2 - 1);
    chk("R5 tx irq empty", tx_thr_irq, 1);
    for (int i = 0; i < DEPTH / 2 - 1; i++) txop("R5", 1, i, 0);
    chk("R5 tx irq at thr", tx_thr_irq, 1);
    txop("R5", 1, 99, 0);
    chk("R5 tx irq above thr", tx_thr_irq, 0);
    for (int i = 0; i < DEPTH / 2 - 1; i++) rxop("R5", 1, i, 0);
    chk("R5 rx irq at thr", rx_thr_irq, 0);
    rxop("R5", 1, 99, 0);
    chk("R5 rx irq above thr", rx_thr_irq, 1);
    while (txq.size() > 0) txop("R5 drain", 0, 0, 1);
    while (rxq.size() > 0) rxop("R5 drain", 0, 0, 1);
    cfgw(4'b0011, 0);
  endtask

  task automatic t_dma();
    rxop("R6", 1, 'h11, 0);
    chk("R6 both disabled", {tx_dma_req, rx_dma_req}, 2'b00);
    dmaw(2'b01);
    chk("R6 rx only", {tx_dma_req, rx_dma_req}, 2'b01);
    dmaw(2'b10);
    chk("R6 tx only", {tx_dma_req, rx_dma_req}, 2'b10);
    dmaw(2'b11);
    chk("R7 wm0 both", {tx_dma_req, rx_dma_req}, 2'b11);
    txop("R7", 1, 'h21, 0);
    chk("R7 tx wm0 one entry", tx_dma_req, 0);
    cfgw(4'b0100, 2);
    chk("R7 tx level under wm", tx_dma_req, 1);
    txop("R7", 1, 'h22, 0);
    chk("R7 tx level at wm", tx_dma_req, 1);
    txop("R7", 1, 'h23, 0);
    chk("R7 tx level over wm", tx_dma_req, 0);
    cfgw(4'b1000, 1);
    chk("R7 rx level at wm", rx_dma_req, 0);
    rxop("R7", 1, 'h12, 0);
    chk("R7 rx level over wm", rx_dma_req, 1);
    while (txq.size() > 0) txop("R7 drain", 0, 0, 1);
    while (rxq.size() > 0) rxop("R7 drain", 0, 0, 1);
    dmaw(2'b00);
    cfgw(4'b1100, 0);
  endtask

  task automatic t_busy();
    engine_busy = 1;
    #1;
    chk("R3 busy bit", status, exp_status(1));
    engine_busy = 0;
    #1;
    chk("R3 busy clear", status, exp_status(0));
    tick();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        t_reset();
        tick();
        t_tx_order();
        t_simul();
        t_tx_quiet();
        t_rx_path();
        t_limits();
        t_irq();
        t_dma();
        t_busy();
      end
      begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule